// File: doc/BRIEF.md
# Priority pad function multiplexer

This block connects three I/O pads to six peripheral functions: three general-purpose lines, a serial transmit line, and the clock and data lines of a two-wire bus. Each pad has a 2-bit function code and an enable bit. On the output side, the pad presents the output value and output enable of the function its code selects. On the input side, the pad's input value is routed back to the function it selects, but only while that function is not driving.

Several pads may select the same function. Outputs then fan out: every such pad shows the same value. Inputs are resolved by a fixed priority in which the lowest-numbered enabled pad wins. All outputs are registered, so each result appears one clock after the inputs that cause it. A synchronous active-high reset clears every output.

Top module: `pmx_core`

## Requirements
- R1: While `rst` is high at a rising edge, every output (`pad_out`, `pad_oe`, `fn_in`) is 0 after that edge.
- R2: Function bit indices are: 0 general-purpose line 0, 1 general-purpose line 1, 2 general-purpose line 2, 3 serial transmit, 4 two-wire data, 5 two-wire clock. Pad p uses code bits `pad_sel[2p+1:2p]`. Pad 0 decodes codes 0/1/3 to functions 0/3/4. Pad 1 decodes codes 1/2 to functions 1/4. Pad 2 decodes codes 0/2 to functions 2/5.
- R3: For an enabled pad with a decoded code, `pad_out[p]` and `pad_oe[p]` equal the selected function's `fn_out` and `fn_oe` bits, one clock after they are applied.
- R4: When serial transmit (function 3) is selected, `pad_oe[p]` is 1 whatever `fn_oe[3]` is. `fn_in[3]` is always 0.
- R5: When function f has `fn_oe[f]`=0 and an enabled pad selects it, `fn_in[f]` equals that pad's `pad_in` one clock later.
- R6: When `fn_oe[f]`=1, `fn_in[f]` is 0 and does not echo any pad.
- R7: When several enabled pads select the same function, the lowest-numbered one drives `fn_in[f]`. For example, pad 0 code 3 overrides pad 1 code 2 for two-wire data.
- R8: A function that no enabled pad selects reads `fn_in[f]`=0, including right after a pad's code moves away from it.
- R9: One function output drives every pad that selects it, all at the same time.
- R10: A pad with `pad_en[p]`=0 has `pad_out[p]`=0 and `pad_oe[p]`=0, and its `pad_in` reaches no function.
- R11: An enabled pad with an unassigned code drives `pad_out[p]`=0 and `pad_oe[p]`=0, and routes no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_sel | input | NUM_PADS*SEL_W | Function code per pad, pad p at bits [2p+1:2p] |
| pad_en | input | NUM_PADS | Per-pad enable |
| pad_in | input | NUM_PADS | Value seen at each pad |
| fn_out | input | NUM_FUNCS | Output value of each function |
| fn_oe | input | NUM_FUNCS | Output enable of each function |
| fn_in | output | NUM_FUNCS | Registered input value returned to each function |
| pad_out | output | NUM_PADS | Registered output value per pad |
| pad_oe | output | NUM_PADS | Registered output enable per pad |

## Verification
The bench builds the block with its default parameters: three pads, 2-bit codes and six functions. With those sizes the random stimulus reaches every code on every pad, including the unassigned ones. It also hits every pad pair that collides on two-wire data, and the interplay of disabled pads with the input priority. Directed steps cover the collision handover from pad 1 to pad 0, a code moving away from a function, and the serial transmit enable override.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PMX_PADS  = 3;
  localparam int PMX_SEL_W = 2;
  localparam int PMX_FUNCS = 6;

  typedef enum logic [2:0] {
    FN_GPIO0   = 3'd0,
    FN_GPIO1   = 3'd1,
    FN_GPIO2   = 3'd2,
    FN_SER_TX  = 3'd3,
    FN_TW_DATA = 3'd4,
    FN_TW_CLK  = 3'd5
  } fn_id_e;

  typedef struct packed {
    logic   hit;
    fn_id_e fn;
  } route_t;

  // Code table per pad; a cleared hit marks an unassigned code.
  function automatic route_t pad_route(input int pad, input logic [PMX_SEL_W-1:0] code);
    route_t r;
    r.hit = 1'b0;
    r.fn  = FN_GPIO0;
    case (pad)
      0: case (code)
           2'd0: begin r.hit = 1'b1; r.fn = FN_GPIO0;   end
           2'd1: begin r.hit = 1'b1; r.fn = FN_SER_TX;  end
           2'd3: begin r.hit = 1'b1; r.fn = FN_TW_DATA; end
           default: ;
         endcase
      1: case (code)
           2'd1: begin r.hit = 1'b1; r.fn = FN_GPIO1;   end
           2'd2: begin r.hit = 1'b1; r.fn = FN_TW_DATA; end
           default: ;
         endcase
      2: case (code)
           2'd0: begin r.hit = 1'b1; r.fn = FN_GPIO2;   end
           2'd2: begin r.hit = 1'b1; r.fn = FN_TW_CLK;  end
           default: ;
         endcase
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic fn_has_input(input int f);
    return (f != int'(FN_SER_TX));
  endfunction
endpackage

// File: rtl/pmx_decode.sv
module pmx_decode
  import pmx_pkg::*;
#(
  parameter int SEL_W     = PMX_SEL_W,
  parameter int NUM_FUNCS = PMX_FUNCS,
  parameter int PAD_IDX   = 0
) (
  input  logic                 en,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_FUNCS-1:0] fn_hot,
  output logic                 code_hit
);
  route_t r;

  always_comb begin
    r        = pad_route(PAD_IDX, sel);
    code_hit = r.hit;
    fn_hot   = '0;
    if (en && r.hit) fn_hot[r.fn] = 1'b1;
  end
endmodule

// File: rtl/pmx_out_lane.sv
module pmx_out_lane #(
  parameter int NUM_FUNCS = 6
) (
  input  logic [NUM_FUNCS-1:0] fn_hot,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe_eff,
  output logic                 lane_out,
  output logic                 lane_oe
);
  always_comb begin
    lane_out = |(fn_hot & fn_out);
    lane_oe  = |(fn_hot & fn_oe_eff);
  end
endmodule

// File: rtl/pmx_in_route.sv
module pmx_in_route
  import pmx_pkg::*;
#(
  parameter int NUM_PADS  = PMX_PADS,
  parameter int NUM_FUNCS = PMX_FUNCS
) (
  input  logic [NUM_PADS*NUM_FUNCS-1:0] hot_all,
  input  logic [NUM_PADS-1:0]           pad_in,
  input  logic [NUM_FUNCS-1:0]          fn_oe,
  output logic [NUM_FUNCS-1:0]          fn_in_c
);
  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
    logic pick;
    // Highest pad first, so the lowest-numbered selecting pad is written last.
    always_comb begin
      pick = 1'b0;
      for (int p = NUM_PADS - 1; p >= 0; p--) begin
        if (hot_all[p*NUM_FUNCS + f]) pick = pad_in[p];
      end
    end
    if (fn_has_input(f)) begin : g_path
      assign fn_in_c[f] = pick & ~fn_oe[f];
    end else begin : g_nopath
      logic unused_pick;
      assign unused_pick = pick;
      assign fn_in_c[f]  = 1'b0;
    end
  end
endmodule

// File: rtl/pmx_core.sv
module pmx_core
  import pmx_pkg::*;
#(
  parameter int NUM_PADS  = PMX_PADS,
  parameter int SEL_W     = PMX_SEL_W,
  parameter int NUM_FUNCS = PMX_FUNCS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PADS*SEL_W-1:0] pad_sel,
  input  logic [NUM_PADS-1:0]       pad_en,
  input  logic [NUM_PADS-1:0]       pad_in,
  input  logic [NUM_FUNCS-1:0]      fn_out,
  input  logic [NUM_FUNCS-1:0]      fn_oe,
  output logic [NUM_FUNCS-1:0]      fn_in,
  output logic [NUM_PADS-1:0]       pad_out,
  output logic [NUM_PADS-1:0]       pad_oe
);
  localparam int HOT_W = NUM_PADS * NUM_FUNCS;
  localparam int SER_I = int'(FN_SER_TX);
  localparam int TWD_I = int'(FN_TW_DATA);

  logic [HOT_W-1:0]     hot_all;
  logic [NUM_PADS-1:0]  code_hit;
  logic [NUM_PADS-1:0]  lane_out_c;
  logic [NUM_PADS-1:0]  lane_oe_c;
  logic [NUM_FUNCS-1:0] fn_in_c;
  logic [NUM_FUNCS-1:0] fn_oe_eff;
  logic                 prev_valid;

  // Serial transmit always drives when selected.
  always_comb begin
    fn_oe_eff        = fn_oe;
    fn_oe_eff[SER_I] = 1'b1;
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pmx_decode #(
      .SEL_W     (SEL_W),
      .NUM_FUNCS (NUM_FUNCS),
      .PAD_IDX   (p)
    ) u_dec (
      .en       (pad_en[p]),
      .sel      (pad_sel[p*SEL_W +: SEL_W]),
      .fn_hot   (hot_all[p*NUM_FUNCS +: NUM_FUNCS]),
      .code_hit (code_hit[p])
    );

    pmx_out_lane #(.NUM_FUNCS(NUM_FUNCS)) u_lane (
      .fn_hot    (hot_all[p*NUM_FUNCS +: NUM_FUNCS]),
      .fn_out    (fn_out),
      .fn_oe_eff (fn_oe_eff),
      .lane_out  (lane_out_c[p]),
      .lane_oe   (lane_oe_c[p])
    );

    // R10: disabled pad is quiet one cycle later
    p_dis_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      (prev_valid && $past(!pad_en[p])) |-> (!pad_out[p] && !pad_oe[p]));

    // R11: enabled pad with unassigned code is quiet
    p_unassigned_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      (prev_valid && $past(pad_en[p] && !code_hit[p])) |-> (!pad_out[p] && !pad_oe[p]));
  end

  pmx_in_route #(
    .NUM_PADS  (NUM_PADS),
    .NUM_FUNCS (NUM_FUNCS)
  ) u_route (
    .hot_all (hot_all),
    .pad_in  (pad_in),
    .fn_oe   (fn_oe),
    .fn_in_c (fn_in_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out    <= '0;
      pad_oe     <= '0;
      fn_in      <= '0;
      prev_valid <= 1'b0;
    end else begin
      pad_out    <= lane_out_c;
      pad_oe     <= lane_oe_c;
      fn_in      <= fn_in_c;
      prev_valid <= 1'b1;
    end
  end

  // R4: serial transmit never returns an input
  p_ser_noinput_r4: assert property (@(posedge clk) disable iff (rst)
    !fn_in[SER_I]);

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fchk
    // R6: a driving function never sees an echo
    p_driving_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      (prev_valid && $past(fn_oe[f])) |-> !fn_in[f]);
  end

  // R7: pad 0 wins two-wire data over pad 1
  p_prio_pad0_r7: assert property (@(posedge clk) disable iff (rst)
    (prev_valid && $past(pad_en[0] && pad_en[1] && pad_sel[1:0] == 2'd3 &&
                         pad_sel[3:2] == 2'd2 && !fn_oe[TWD_I]))
    |-> (fn_in[TWD_I] == $past(pad_in[0])));
endmodule

// File: tb/pmx_core_tb_top.sv
`timescale 1ns/1ps
module pmx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] pad_sel;
  logic [2:0] pad_en, pad_in;
  logic [5:0] fn_out, fn_oe;
  logic [5:0] fn_in;
  logic [2:0] pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmx_core dut_i (
    .clk(clk), .rst(rst), .pad_sel(pad_sel), .pad_en(pad_en), .pad_in(pad_in),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic int map_fn(int pad, int code);
    if (pad == 0) begin
      if (code == 0) return 0;
      if (code == 1) return 3;
      if (code == 3) return 4;
    end else if (pad == 1) begin
      if (code == 1) return 1;
      if (code == 2) return 4;
    end else if (pad == 2) begin
      if (code == 0) return 2;
      if (code == 2) return 5;
    end
    return -1;
  endfunction

  function automatic int pad_fn(int p);
    if (!pad_en[p]) return -1;
    return map_fn(p, int'(pad_sel[2*p +: 2]));
  endfunction

  function automatic logic [2:0] exp_out();
    logic [2:0] v = '0;
    for (int p = 0; p < 3; p++) begin
      int f = pad_fn(p);
      if (f >= 0) v[p] = fn_out[f];
    end
    return v;
  endfunction

  function automatic logic [2:0] exp_oe();
    logic [2:0] v = '0;
    for (int p = 0; p < 3; p++) begin
      int f = pad_fn(p);
      if (f >= 0) v[p] = (f == 3) ? 1'b1 : fn_oe[f];
    end
    return v;
  endfunction

  function automatic logic [5:0] exp_in();
    logic [5:0] v = '0;
    for (int f = 0; f < 6; f++) begin
      bit found = 0;
      for (int p = 0; p < 3; p++) begin
        if (!found && pad_fn(p) == f) begin
          v[f] = pad_in[p];
          found = 1;
        end
      end
      if (f == 3 || fn_oe[f]) v[f] = 1'b0;
    end
    return v;
  endfunction

  logic [2:0] e_out, e_oe;
  logic [5:0] e_in;

  // Inputs are driven at the falling edge, captured at the rising edge,
  // and checked at the following falling edge.
  task automatic step_check(input string tag);
    e_out = exp_out();
    e_oe  = exp_oe();
    e_in  = exp_in();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (pad_out !== e_out || pad_oe !== e_oe || fn_in !== e_in) begin
      failures++;
      $display("FAIL %s: pad_out=%b pad_oe=%b fn_in=%b expected pad_out=%b pad_oe=%b fn_in=%b",
               tag, pad_out, pad_oe, fn_in, e_out, e_oe, e_in);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    pad_sel = 6'b111111; pad_en = 3'b111; pad_in = 3'b111;
    fn_out = 6'b111111; fn_oe = 6'b000000;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (pad_out !== 3'b0 || pad_oe !== 3'b0 || fn_in !== 6'b0) begin
      failures++;
      $display("FAIL R1 reset: pad_out=%b pad_oe=%b fn_in=%b expected all 0", pad_out, pad_oe, fn_in);
    end
    rst = 1'b0;

    // R2/R3: pad 2 code 0 general-purpose line 2 output follows
    pad_en = 3'b100; pad_sel = 6'b00_00_00; fn_oe = 6'b000100; fn_out = 6'b000000;
    step_check("R3 gpio2 out=0");
    fn_out = 6'b000100;
    step_check("R3 gpio2 out=1");

    // R5: input routing with enable low
    fn_oe = 6'b0; pad_in = 3'b000;
    step_check("R5 gpio2 in=0");
    pad_in = 3'b100;
    step_check("R5 gpio2 in=1");

    // R6: driving function does not echo pad
    fn_oe = 6'b000100;
    step_check("R6 gpio2 driving no echo");

    // R4: serial transmit on pad 0, enable forced
    pad_en = 3'b001; pad_sel = 6'b00_00_01; fn_oe = 6'b000000; fn_out = 6'b001000; pad_in = 3'b111;
    step_check("R4 ser tx oe forced, no input");

    // R7: collision on two-wire data
    pad_en = 3'b011; pad_sel = 6'b00_10_00; fn_oe = 6'b0; pad_in = 3'b001;
    step_check("R7 pad1 tw data, pad0 gpio0");
    pad_sel = 6'b00_10_11;
    step_check("R7 pad0 overrides pad1");

    // R8: pad 1 moves away, pad 0 code moves to gpio0 => tw data reads 0 unless pad0
    pad_sel = 6'b00_01_11; pad_in = 3'b011;
    step_check("R8 pad1 to gpio1 keeps pad0 data");
    pad_sel = 6'b00_01_00; pad_in = 3'b010;
    step_check("R8 tw data unselected reads 0");

    // R9: one function drives two pads
    pad_sel = 6'b00_10_11; fn_oe = 6'b010000; fn_out = 6'b010000;
    step_check("R9 fan-out tw data to pads 0 and 1");

    // R10: disabled pad quiet and does not route
    pad_en = 3'b010; pad_sel = 6'b00_10_11; fn_oe = 6'b0; pad_in = 3'b001;
    step_check("R10 pad0 disabled, pad1 routes");

    // R11: unassigned codes
    pad_en = 3'b111; pad_sel = 6'b11_11_10; fn_out = 6'b111111; fn_oe = 6'b111111;
    step_check("R11 unassigned codes quiet");

    // Random mix across all requirements (R2 R3 R5 R7 R9 R10 R11)
    for (int i = 0; i < 3000; i++) begin
      pad_sel = 6'($urandom);
      pad_en  = 3'($urandom);
      pad_in  = 3'($urandom);
      fn_out  = 6'($urandom);
      fn_oe   = 6'($urandom);
      step_check("R2 random mix");
    end

    finish_run();
  end
endmodule